// File: doc/BRIEF.md
# CAN Controller Interrupt Collector

This block collects the interrupt causes of a CAN FD controller into one status register, one enable mask and a single interrupt line for the host. The protocol engine sends one-cycle event pulses for error warning, error-state change, arbitration loss, receive overrun, bus error and bit-rate switch. The receive buffer supplies a level flag that shows whether it is empty. Each transmit buffer has its own request line. A transmit buffer raises its request only when a hardware command finishes it: the frame was sent, the transmission failed, or it was aborted.

Status bits are sticky. The host clears a bit by writing 1 to it in the clear register. The enable mask has its own set strobe and its own clear strobe, so a single enable can change without a read-modify-write. The interrupt line is a level. It stays high for as long as any enabled status bit is set. The receive-not-empty bit works from a condition rather than an event: while the receive buffer holds data, clearing the bit has no lasting effect.

Top module: `can_irq_collector`

## Requirements
- R1: While reset is low, and on the first cycle after it, the status, the enable mask and irq are all zero.
- R2: A one-cycle pulse on an event input sets only its own status bit on the next clock edge. The bit positions are: error warning at bit 0, error-state change at bit 1, arbitration lost at bit 2, receive overrun at bit 3, bus error at bit 4, bit-rate switch at bit 5.
- R3: A status bit stays set after its event pulse ends, until the host clears it.
- R4: When clr_we is high, each 1 in wr_data clears the matching status bit. Each 0 leaves its bit unchanged.
- R5: If an event arrives in the same cycle as a clear of its bit, the bit stays set.
- R6: When any bit of txb_done_req is set, status bit 11 is set. Several requests in the same cycle still set only bit 11.
- R7: Status bit 6 (receive not empty) is set on every cycle in which rx_empty is low. A clear of bit 6 while rx_empty is low leaves it set. A clear while rx_empty is high removes it.
- R8: Status bits latch their events whether or not the matching enable bit is set.
- R9: When ena_set_we is high, each 1 in wr_data sets the matching enable bit. When ena_clr_we is high, each 1 clears the matching enable bit. Bits written as 0 are unchanged. If both strobes are high, set wins.
- R10: irq is high in every cycle in which some status bit and its enable bit are both set, and low in every other cycle.
- R11: Status and enable bits 7 to 10 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_err_warn | input | 1 | Error warning event pulse |
| ev_err_state | input | 1 | Error passive / bus-off change pulse |
| ev_arb_lost | input | 1 | Arbitration lost pulse |
| ev_overrun | input | 1 | Receive data overrun pulse |
| ev_bus_err | input | 1 | Bus error pulse |
| ev_rate_shift | input | 1 | Bit-rate switched pulse |
| rx_empty | input | 1 | Receive buffer holds no unread data |
| txb_done_req | input | NTXB | Per-transmit-buffer completion request |
| wr_data | input | 12 | Write data for the clear and enable strobes |
| clr_we | input | 1 | Write-one-to-clear strobe for status |
| ena_set_we | input | 1 | Write-one-to-set strobe for enable |
| ena_clr_we | input | 1 | Write-one-to-clear strobe for enable |
| int_status | output | 12 | Status register |
| int_enable | output | 12 | Enable mask |
| irq | output | 1 | Level interrupt output |

## Verification
Each event is pulsed on its own with the mask disabled. This shows that every cause lands on its own bit and that latching does not depend on the enable. Clears are written with partial masks, and some arrive in the same cycle as an event. These cases separate a write-one-to-clear from a plain overwrite, and show that an event wins over a clear. The receive flag is held non-empty across a clear and then released before a second clear, which separates condition-driven re-assertion from a one-time event. The transmit request vector is driven with a single bit, then with several bits, then with none, to confirm the OR-reduction. Enables are changed one at a time to show that irq follows only enabled bits.

// File: rtl/can_irq_pkg.sv
// Package: status layout shared by the interrupt collector and its checker.
// Assumes a 12-bit status word; bit 11 is decoded by the host for the
// transmit-buffer completion cause, so its position is fixed.
package can_irq_pkg;
    localparam int ST_W     = 12;
    localparam int B_EWARN  = 0;
    localparam int B_ESTATE = 1;
    localparam int B_ALOST  = 2;
    localparam int B_OVRUN  = 3;
    localparam int B_BUSERR = 4;
    localparam int B_RSHIFT = 5;
    localparam int B_RXNE   = 6;
    localparam int B_TXDONE = 11;

    typedef logic [ST_W-1:0] irq_vec_t;

    // Bits that hold real causes; all others are reserved and read zero.
    localparam irq_vec_t IMPL_MASK = irq_vec_t'((1 << B_EWARN) | (1 << B_ESTATE) |
        (1 << B_ALOST) | (1 << B_OVRUN) | (1 << B_BUSERR) | (1 << B_RSHIFT) |
        (1 << B_RXNE) | (1 << B_TXDONE));
endpackage

// File: rtl/can_irq_src_map.sv
// Module: maps raw interrupt causes onto the status bit layout.
// Assumes event inputs are single-cycle pulses and rx_empty is a level.
// Purely combinational.
module can_irq_src_map
    import can_irq_pkg::*;
#(
    parameter int NTXB = 4
) (
    input  logic            ev_err_warn,
    input  logic            ev_err_state,
    input  logic            ev_arb_lost,
    input  logic            ev_overrun,
    input  logic            ev_bus_err,
    input  logic            ev_rate_shift,
    input  logic            rx_empty,
    input  logic [NTXB-1:0] txb_done_req,
    output irq_vec_t        set_vec
);
    // Place each cause at its bit; the transmit requests collapse to one bit.
    always_comb begin
        set_vec           = '0;
        set_vec[B_EWARN]  = ev_err_warn;
        set_vec[B_ESTATE] = ev_err_state;
        set_vec[B_ALOST]  = ev_arb_lost;
        set_vec[B_OVRUN]  = ev_overrun;
        set_vec[B_BUSERR] = ev_bus_err;
        set_vec[B_RSHIFT] = ev_rate_shift;
        set_vec[B_RXNE]   = ~rx_empty;
        set_vec[B_TXDONE] = |txb_done_req;
    end
endmodule

// File: rtl/can_irq_status.sv
// Module: sticky status bits with write-one-to-clear.
// Assumes set has priority over clear; bits outside IMPL read zero.
module can_irq_status #(
    parameter int              W    = 12,
    parameter logic [W-1:0]    IMPL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic         clr_we,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] status
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (IMPL[i]) begin : g_impl
            // Hold the bit until a clear; a same-cycle cause wins.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    status[i] <= 1'b0;
                else if (set_vec[i])
                    status[i] <= 1'b1;
                else if (clr_we && clr_mask[i])
                    status[i] <= 1'b0;
            end
        end else begin : g_rsvd
            assign status[i] = 1'b0;
        end
    end
endmodule

// File: rtl/can_irq_enable.sv
// Module: enable mask with separate write-one-to-set and write-one-to-clear.
// Assumes set wins when both strobes hit the same bit.
module can_irq_enable #(
    parameter int              W    = 12,
    parameter logic [W-1:0]    IMPL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] wdata,
    input  logic         set_we,
    input  logic         clr_we,
    output logic [W-1:0] enable
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (IMPL[i]) begin : g_impl
            // Update one enable bit from the set and clear strobes.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    enable[i] <= 1'b0;
                else if (set_we && wdata[i])
                    enable[i] <= 1'b1;
                else if (clr_we && wdata[i])
                    enable[i] <= 1'b0;
            end
        end else begin : g_rsvd
            assign enable[i] = 1'b0;
        end
    end
endmodule

// File: rtl/can_irq_collector.sv
// Top: CAN controller interrupt collector.
// Latches causes into sticky status, masks them with the enable register and
// drives a level interrupt. Assumes a synchronous active-low reset.
module can_irq_collector
    import can_irq_pkg::*;
#(
    parameter int NTXB = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ev_err_warn,
    input  logic            ev_err_state,
    input  logic            ev_arb_lost,
    input  logic            ev_overrun,
    input  logic            ev_bus_err,
    input  logic            ev_rate_shift,
    input  logic            rx_empty,
    input  logic [NTXB-1:0] txb_done_req,
    input  logic [11:0]     wr_data,
    input  logic            clr_we,
    input  logic            ena_set_we,
    input  logic            ena_clr_we,
    output logic [11:0]     int_status,
    output logic [11:0]     int_enable,
    output logic            irq
);
    irq_vec_t set_vec;

    can_irq_src_map #(.NTXB(NTXB)) u_map (
        .ev_err_warn   (ev_err_warn),
        .ev_err_state  (ev_err_state),
        .ev_arb_lost   (ev_arb_lost),
        .ev_overrun    (ev_overrun),
        .ev_bus_err    (ev_bus_err),
        .ev_rate_shift (ev_rate_shift),
        .rx_empty      (rx_empty),
        .txb_done_req  (txb_done_req),
        .set_vec       (set_vec)
    );

    can_irq_status #(.W(ST_W), .IMPL(IMPL_MASK)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_vec),
        .clr_we   (clr_we),
        .clr_mask (wr_data),
        .status   (int_status)
    );

    can_irq_enable #(.W(ST_W), .IMPL(IMPL_MASK)) u_enable (
        .clk    (clk),
        .rst_n  (rst_n),
        .wdata  (wr_data),
        .set_we (ena_set_we),
        .clr_we (ena_clr_we),
        .enable (int_enable)
    );

    // Level output: high while any enabled cause is pending.
    assign irq = |(int_status & int_enable);
endmodule

// File: rtl/can_irq_collector_chk.sv
// Checker: temporal properties of the interrupt collector, bound to the top.
module can_irq_collector_chk #(
    parameter int NTXB = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ev_bus_err,
    input logic            rx_empty,
    input logic [NTXB-1:0] txb_done_req,
    input logic [11:0]     wr_data,
    input logic            clr_we,
    input logic            ena_set_we,
    input logic [11:0]     int_status,
    input logic [11:0]     int_enable,
    input logic            irq
);
    // R1
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |=> (int_status == 12'h0 && int_enable == 12'h0 && !irq));
    // R3
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_we |=> ((int_status & $past(int_status)) == $past(int_status)));
    // R5
    event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_bus_err |=> int_status[4]);
    // R6
    txdone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|txb_done_req) |=> int_status[11]);
    // R7
    rxne_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_empty |=> int_status[6]);
    // R9
    ena_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ena_set_we |=> ((int_enable & ($past(wr_data) & 12'h87F)) == ($past(wr_data) & 12'h87F)));
    // R10
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_enable == 12'h0 || int_status == 12'h0) |-> !irq);
endmodule

bind can_irq_collector can_irq_collector_chk #(.NTXB(NTXB)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev_bus_err   (ev_bus_err),
    .rx_empty     (rx_empty),
    .txb_done_req (txb_done_req),
    .wr_data      (wr_data),
    .clr_we       (clr_we),
    .ena_set_we   (ena_set_we),
    .int_status   (int_status),
    .int_enable   (int_enable),
    .irq          (irq)
);

// File: tb/can_irq_collector_test.sv
// Bench: scoreboard. The driver task applies one cycle of stimulus and
// pushes the expected register state; the monitor compares after the edge.
module can_irq_collector_test;
    localparam int NTXB = 4;
    localparam logic [11:0] IMPL = 12'h87F;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [5:0]      ev = '0;
    logic            rx_empty = 1'b1;
    logic [NTXB-1:0] txreq = '0;
    logic [11:0]     wr_data = '0;
    logic            clr_we = 1'b0, ena_set_we = 1'b0, ena_clr_we = 1'b0;
    logic [11:0]     int_status, int_enable;
    logic            irq;

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct {
        logic [11:0] st;
        logic [11:0] en;
        logic        irq;
        string       tag;
    } exp_t;
    exp_t q[$];

    logic [11:0] m_st = '0;
    logic [11:0] m_en = '0;

    always #4 clk = ~clk;

    can_irq_collector #(.NTXB(NTXB)) uut (
        .clk(clk), .rst_n(rst_n),
        .ev_err_warn(ev[0]), .ev_err_state(ev[1]), .ev_arb_lost(ev[2]),
        .ev_overrun(ev[3]), .ev_bus_err(ev[4]), .ev_rate_shift(ev[5]),
        .rx_empty(rx_empty), .txb_done_req(txreq), .wr_data(wr_data),
        .clr_we(clr_we), .ena_set_we(ena_set_we), .ena_clr_we(ena_clr_we),
        .int_status(int_status), .int_enable(int_enable), .irq(irq)
    );

    // Driver: one cycle of stimulus plus the expected state after the edge.
    task automatic cyc(input logic [5:0] e, input logic rxe, input logic [NTXB-1:0] tx,
                       input logic c, input logic es, input logic ec,
                       input logic [11:0] d, input string tag);
        logic [11:0] setv;
        exp_t x;
        @(negedge clk);
        ev = e; rx_empty = rxe; txreq = tx; clr_we = c;
        ena_set_we = es; ena_clr_we = ec; wr_data = d;
        setv = {(|tx), 4'b0000, ~rxe, e};
        m_st = ((m_st & ~(c ? d : 12'h0)) | setv) & IMPL;
        m_en = ((m_en & ~(ec ? d : 12'h0)) | (es ? d : 12'h0)) & IMPL;
        x.st = m_st; x.en = m_en; x.irq = |(m_st & m_en); x.tag = tag;
        q.push_back(x);
    endtask

    task automatic idle(input string tag);
        cyc(6'h0, 1'b1, '0, 1'b0, 1'b0, 1'b0, 12'h0, tag);
    endtask

    task automatic clr(input logic [11:0] d, input string tag);
        cyc(6'h0, 1'b1, '0, 1'b1, 1'b0, 1'b0, d, tag);
    endtask

    // Monitor: compare after each clock edge.
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t x;
            x = q.pop_front();
            n_cmp++;
            if (int_status !== x.st || int_enable !== x.en || irq !== x.irq) begin
                n_bad++;
                $display("FAIL %s: got st=%h en=%h irq=%b, exp st=%h en=%h irq=%b",
                         x.tag, int_status, int_enable, irq, x.st, x.en, x.irq);
            end
        end
    end

    // Watchdog
    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: got timeout, exp completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: outputs during reset
        repeat (3) @(negedge clk);
        n_cmp++;
        if (int_status !== 12'h0 || int_enable !== 12'h0 || irq !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: got st=%h en=%h irq=%b, exp 0/0/0", int_status, int_enable, irq);
        end
        rst_n = 1'b1;
        idle("R1");

        // R2 / R8: each event alone, enables off
        for (int i = 0; i < 6; i++) begin
            cyc(6'(1 << i), 1'b1, '0, 1'b0, 1'b0, 1'b0, 12'h0, "R2_R8");
            idle("R3");
            clr(12'hFFF, "R4");
        end

        // R3: sticky over several idle cycles
        cyc(6'b001010, 1'b1, '0, 1'b0, 1'b0, 1'b0, 12'h0, "R2");
        repeat (3) idle("R3");
        // R4: partial clear, zero bits untouched
        clr(12'h008, "R4");
        clr(12'h000, "R4");
        clr(12'h002, "R4");

        // R5: event and clear of the same bit together
        cyc(6'b010000, 1'b1, '0, 1'b0, 1'b0, 1'b0, 12'h0, "R5");
        cyc(6'b010000, 1'b1, '0, 1'b1, 1'b0, 1'b0, 12'h010, "R5");
        idle("R5");
        clr(12'h010, "R5");

        // R6: single, multiple, none
        cyc(6'h0, 1'b1, 4'b0100, 1'b0, 1'b0, 1'b0, 12'h0, "R6");
        clr(12'h800, "R6");
        cyc(6'h0, 1'b1, 4'b1011, 1'b0, 1'b0, 1'b0, 12'h0, "R6");
        idle("R6");
        clr(12'h800, "R6");

        // R7: receive not empty is condition driven
        cyc(6'h0, 1'b0, '0, 1'b0, 1'b0, 1'b0, 12'h0, "R7");
        cyc(6'h0, 1'b0, '0, 1'b1, 1'b0, 1'b0, 12'h040, "R7");
        cyc(6'h0, 1'b0, '0, 1'b0, 1'b0, 1'b0, 12'h0, "R7");
        idle("R7");
        clr(12'h040, "R7");

        // R9 / R10: enables and the level output
        cyc(6'b000001, 1'b1, '0, 1'b0, 1'b0, 1'b0, 12'h0, "R10");
        cyc(6'h0, 1'b1, '0, 1'b0, 1'b1, 1'b0, 12'h004, "R9_R10");
        cyc(6'h0, 1'b1, '0, 1'b0, 1'b1, 1'b0, 12'h001, "R9_R10");
        repeat (2) idle("R10");
        cyc(6'h0, 1'b1, '0, 1'b0, 1'b0, 1'b1, 12'h001, "R9_R10");
        cyc(6'h0, 1'b1, '0, 1'b0, 1'b1, 1'b1, 12'h005, "R9");
        clr(12'h001, "R10");
        cyc(6'b000100, 1'b1, '0, 1'b0, 1'b0, 1'b0, 12'h0, "R10");
        clr(12'h004, "R10");

        // R11: reserved bits
        cyc(6'h3F, 1'b0, 4'b0001, 1'b0, 1'b1, 1'b0, 12'hFFF, "R11");
        cyc(6'h0, 1'b1, '0, 1'b1, 1'b0, 1'b1, 12'hFFF, "R11");
        idle("R11");

        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule